// File: doc/BRIEF.md
# Register-indirect jump, call and return sequencer

This block is the control-transfer slice of a small 8-bit microcontroller core. It executes jumps and calls whose target comes from the 16-bit pointer pair Z. It also executes the subroutine return that undoes a call. One decode covers the whole indirect family. One opcode bit widens the target to 24 bits by taking the top byte from an extension register. A second opcode bit makes the instruction a call, which pushes a 16-bit return address onto the byte-wide data stack.

The surrounding core raises `start_i` for one cycle with the opcode, Z, the extension byte, the word address of the current instruction and the stack pointer. The block then runs the stack traffic one byte per cycle on a simple memory port. In its last cycle it pulses `done_o` together with the next PC, the updated stack pointer and the number of cycles the instruction took. A configuration without the extension register (`HAS_EXT = 0`) rejects the widened forms. So does any opcode outside the supported set.

Top module: `ijc_unit`

## Requirements
- R1: The instruction is picked by the opcode. 0x9409 is an indirect jump, 0x9419 an extended indirect jump, 0x9509 an indirect call, 0x9519 an extended indirect call and 0x9508 a return. Within the indirect family, opcode bit 4 selects the extended form and opcode bit 8 selects a call. Any other opcode is invalid and is handled as in R3.
- R2: A jump or call sets the next PC to Z zero-extended. In the extended form, `ext_i` supplies bits 23:16 of the target. The non-extended form ignores `ext_i`.
- R3: An invalid instruction raises `bad_op_o` together with `done_o` in cycle 2 and reports 2 cycles. It gives next PC = pc+1, leaves SP unchanged and makes no memory access. With `HAS_EXT = 0`, 0x9419 and 0x9519 are invalid.
- R4: A call pushes the low 16 bits of pc+1. The low byte is written at SP in cycle 2 and the high byte at SP-1 in cycle 3, and `sp_o` reports SP-2.
- R5: A return reads the high byte at SP+1 in cycle 2 and the low byte at SP+2 in cycle 3. In cycle 4 it reports next PC = {high,low} zero-extended and `sp_o` = SP+2.
- R6: `done_o` is high for exactly one cycle, the last cycle of the instruction. `cycles_o` then holds 2 for a jump, 3 for a call and 4 for a return.
- R7: Stack addresses and SP wrap modulo 2^16, with no overflow indication.
- R8: `busy_o` is high from the cycle after acceptance through the `done_o` cycle. `start_i` is ignored while `busy_o` is high.
- R9: After reset the block is idle: `busy_o`, `done_o`, `mem_we_o` and `mem_re_o` are low.

Cycle 1 is the cycle in which `start_i` is sampled high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Issue the presented instruction |
| op_i | input | 16 | Opcode |
| z_i | input | 16 | Z pointer pair (ZH:ZL) |
| ext_i | input | 8 | Extension byte for target bits 23:16 |
| pc_i | input | PC_W | Word address of the current instruction |
| sp_i | input | SP_W | Stack pointer at issue |
| mem_rdata_i | input | 8 | Stack read data, valid in the cycle of the read |
| mem_we_o | output | 1 | Stack byte write strobe |
| mem_re_o | output | 1 | Stack byte read strobe |
| mem_addr_o | output | SP_W | Stack byte address |
| mem_wdata_o | output | 8 | Stack write data |
| done_o | output | 1 | Last cycle of the instruction |
| busy_o | output | 1 | Instruction in progress |
| bad_op_o | output | 1 | Invalid instruction, valid with done_o |
| next_pc_o | output | PC_W | Next PC word address, valid with done_o |
| sp_o | output | SP_W | Updated stack pointer, valid with done_o |
| cycles_o | output | 3 | Cycle count, valid with done_o |

## Verification
The bench checks the byte order on the stack in both directions, low-then-high on push and high-then-low on pop. A design with either order swapped returns to a byte-swapped address. It runs calls and returns across SP = 0x0000 and 0xFFFF. A design that saturated or carried into a wider pointer would write to the wrong place or report the wrong SP. A second instance with no extension register is given the widened opcodes and must flag them with no stack traffic. A call is issued whose return address carries out of the low 16 bits, and `start_i` is re-raised mid-call. A design that latched the new request would corrupt the stack sequence.

// File: rtl/ijc_pkg.sv
package ijc_pkg;

  localparam logic [15:0] OP_FAM_MASK = 16'hFEEF;
  localparam logic [15:0] OP_FAM_BASE = 16'h9409;
  localparam logic [15:0] OP_RETURN   = 16'h9508;
  localparam int          XSEL_BIT    = 4;
  localparam int          CALL_BIT    = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_JMP_END,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_POP_HI,
    ST_POP_LO,
    ST_RET_END,
    ST_BAD_END
  } ijc_state_e;

  typedef struct packed {
    logic xfer;
    logic wide;
    logic call;
    logic ret;
    logic bad;
  } ijc_dec_t;

  function automatic logic [2:0] cost_of(ijc_state_e s);
    case (s)
      ST_JMP_END: return 3'd2;
      ST_BAD_END: return 3'd2;
      ST_PUSH_HI: return 3'd3;
      ST_RET_END: return 3'd4;
      default:    return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/ijc_decode.sv
module ijc_decode #(
  parameter bit HAS_EXT = 1'b1
) (
  input  logic [15:0]       op_i,
  output ijc_pkg::ijc_dec_t dec_o
);
  import ijc_pkg::*;

  logic fam;
  logic is_ret;
  logic wide_rej;

  always_comb begin
    fam      = (op_i & OP_FAM_MASK) == OP_FAM_BASE;
    is_ret   = op_i == OP_RETURN;
    wide_rej = fam && op_i[XSEL_BIT] && !HAS_EXT;
    dec_o.xfer = fam && !wide_rej;
    dec_o.wide = fam && op_i[XSEL_BIT];
    dec_o.call = fam && op_i[CALL_BIT] && !wide_rej;
    dec_o.ret  = is_ret;
    dec_o.bad  = !(fam || is_ret) || wide_rej;
  end

endmodule

// File: rtl/ijc_target.sv
module ijc_target #(
  parameter int PC_W    = 24,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic [15:0]     z_i,
  input  logic [7:0]      ext_i,
  input  logic            wide_i,
  output logic [PC_W-1:0] tgt_o
);
  localparam int HI_W = PC_W - 16;

  generate
    if (HI_W > 0 && HAS_EXT) begin : g_wide
      logic [HI_W-1:0] hi;
      assign hi    = wide_i ? ext_i[HI_W-1:0] : '0;
      assign tgt_o = {hi, z_i};
    end else if (HI_W > 0) begin : g_zext
      logic unused_ext;
      assign unused_ext = ^{ext_i, wide_i};
      assign tgt_o = {{HI_W{1'b0}}, z_i};
    end else begin : g_narrow
      logic unused_ext;
      assign unused_ext = ^{ext_i, wide_i};
      assign tgt_o = z_i[PC_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/ijc_sp.sv
module ijc_sp #(
  parameter int SP_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [SP_W-1:0] load_val_i,
  input  logic            dec_i,
  input  logic            inc_i,
  output logic [SP_W-1:0] sp_q_o,
  output logic [SP_W-1:0] sp_d_o
);
  logic [SP_W-1:0] sp_q;

  always_comb begin
    sp_d_o = sp_q;
    if (load_i)     sp_d_o = load_val_i;
    else if (dec_i) sp_d_o = sp_q - 1'b1;
    else if (inc_i) sp_d_o = sp_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= '0;
    else         sp_q <= sp_d_o;
  end

  assign sp_q_o = sp_q;

endmodule

// File: rtl/ijc_seq.sv
module ijc_seq (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  ijc_pkg::ijc_dec_t   dec_i,
  output ijc_pkg::ijc_state_e state_o,
  output logic                accept_o
);
  import ijc_pkg::*;

  ijc_state_e state_q, state_d;

  assign accept_o = start_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) begin
        if (dec_i.bad)       state_d = ST_BAD_END;
        else if (dec_i.ret)  state_d = ST_POP_HI;
        else if (dec_i.call) state_d = ST_PUSH_LO;
        else                 state_d = ST_JMP_END;
      end
      ST_PUSH_LO: state_d = ST_PUSH_HI;
      ST_POP_HI:  state_d = ST_POP_LO;
      ST_POP_LO:  state_d = ST_RET_END;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/ijc_unit.sv
module ijc_unit #(
  parameter int PC_W    = 24,
  parameter int SP_W    = 16,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [15:0]     op_i,
  input  logic [15:0]     z_i,
  input  logic [7:0]      ext_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [SP_W-1:0] sp_i,
  input  logic [7:0]      mem_rdata_i,
  output logic            mem_we_o,
  output logic            mem_re_o,
  output logic [SP_W-1:0] mem_addr_o,
  output logic [7:0]      mem_wdata_o,
  output logic            done_o,
  output logic            busy_o,
  output logic            bad_op_o,
  output logic [PC_W-1:0] next_pc_o,
  output logic [SP_W-1:0] sp_o,
  output logic [2:0]      cycles_o
);
  import ijc_pkg::*;

  localparam int RA_W = 16;

  ijc_dec_t        dec;
  ijc_state_e      state;
  logic            accept;
  logic [PC_W-1:0] tgt;
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] npc_q;
  logic [RA_W-1:0] ra_q;
  logic [SP_W-1:0] sp_q, sp_d;
  logic            in_push, in_pop;

  ijc_decode #(.HAS_EXT(HAS_EXT)) u_dec (
    .op_i  (op_i),
    .dec_o (dec)
  );

  ijc_target #(.PC_W(PC_W), .HAS_EXT(HAS_EXT)) u_tgt (
    .z_i    (z_i),
    .ext_i  (ext_i),
    .wide_i (dec.wide),
    .tgt_o  (tgt)
  );

  ijc_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .dec_i    (dec),
    .state_o  (state),
    .accept_o (accept)
  );

  assign in_push = (state == ST_PUSH_LO) || (state == ST_PUSH_HI);
  assign in_pop  = (state == ST_POP_HI)  || (state == ST_POP_LO);

  ijc_sp #(.SP_W(SP_W)) u_sp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (sp_i),
    .dec_i      (in_push),
    .inc_i      (in_pop),
    .sp_q_o     (sp_q),
    .sp_d_o     (sp_d)
  );

  assign pc_inc = pc_i + 1'b1;

  // npc_q: target for transfers, pc+1 for rejects, assembled bytes for returns
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      npc_q <= '0;
      ra_q  <= '0;
    end else if (accept) begin
      ra_q <= pc_inc[RA_W-1:0];
      if (dec.bad)      npc_q <= pc_inc;
      else if (dec.ret) npc_q <= '0;
      else              npc_q <= tgt;
    end else if (state == ST_POP_HI) begin
      npc_q[15:8] <= mem_rdata_i;
    end else if (state == ST_POP_LO) begin
      npc_q[7:0] <= mem_rdata_i;
    end
  end

  always_comb begin
    mem_we_o    = in_push;
    mem_re_o    = in_pop;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    if (in_push) mem_addr_o = sp_q;
    if (in_pop)  mem_addr_o = sp_q + 1'b1;
    if (state == ST_PUSH_LO) mem_wdata_o = ra_q[7:0];
    if (state == ST_PUSH_HI) mem_wdata_o = ra_q[15:8];
  end

  assign done_o    = (state == ST_JMP_END) || (state == ST_PUSH_HI) ||
                     (state == ST_RET_END) || (state == ST_BAD_END);
  assign busy_o    = state != ST_IDLE;
  assign bad_op_o  = state == ST_BAD_END;
  assign next_pc_o = done_o ? npc_q : '0;
  assign sp_o      = sp_d;
  assign cycles_o  = cost_of(state);

endmodule

// File: rtl/ijc_unit_chk.sv
module ijc_unit_chk #(
  parameter int SP_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            mem_we_o,
  input logic            mem_re_o,
  input logic [SP_W-1:0] mem_addr_o,
  input logic            done_o,
  input logic            busy_o,
  input logic            bad_op_o,
  input logic [SP_W-1:0] sp_o,
  input logic [2:0]      cycles_o
);

  // R4: second push byte lands one below the first
  a_r4_push_descends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !done_o) |=> (mem_we_o && mem_addr_o == $past(mem_addr_o) - 1'b1));

  // R4: reported SP is one below the last byte written
  a_r4_call_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mem_we_o) |-> (sp_o == mem_addr_o - 1'b1));

  // R5: second pop byte one above the first
  a_r5_pop_ascends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_re_o) |=> (mem_re_o && mem_addr_o == $past(mem_addr_o) + 1'b1));

  // R5: return completes right after the second read
  a_r5_ret_finish: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && !$rose(mem_re_o)) |=> (done_o && !mem_re_o && sp_o == $past(mem_addr_o)));

  // R3: a reject touches no memory
  a_r3_bad_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_op_o |-> (done_o && !mem_we_o && !mem_re_o && cycles_o == 3'd2));

  // R6: one-cycle done pulse with a legal count
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_cycles_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cycles_o >= 3'd2 && cycles_o <= 3'd4));

  // R8: acceptance makes the unit busy
  a_r8_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R9: idle means no traffic
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_we_o && !mem_re_o && !done_o));

endmodule

bind ijc_unit ijc_unit_chk #(.SP_W(SP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mem_we_o   (mem_we_o),
  .mem_re_o   (mem_re_o),
  .mem_addr_o (mem_addr_o),
  .done_o     (done_o),
  .busy_o     (busy_o),
  .bad_op_o   (bad_op_o),
  .sp_o       (sp_o),
  .cycles_o   (cycles_o)
);

// File: tb/sim_ijc_unit.sv
`timescale 1ns/1ps
module sim_ijc_unit;
  localparam int PC_W = 24;

  typedef struct {
    bit          we, re, done, bad, busy;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [23:0] npc;
    logic [15:0] sp;
    logic [2:0]  cyc;
    int          req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] op = '0, z = '0, sp_in = '0;
  logic [7:0]  ext = '0;
  logic [23:0] pc = '0;
  logic [7:0]  rdata = '0;

  logic        we, re, done, busy, bad;
  logic [15:0] addr, sp_out;
  logic [7:0]  wdata;
  logic [23:0] npc;
  logic [2:0]  cyc;

  logic        n_we, n_re, n_done, n_busy, n_bad;
  logic [15:0] n_addr, n_sp;
  logic [7:0]  n_wdata;
  logic [23:0] n_npc;
  logic [2:0]  n_cyc;

  int vectors = 0;
  int miscompares = 0;
  bit run = 1'b0;

  logic [7:0] mem  [bit [15:0]];
  logic [7:0] mmem [bit [15:0]];
  exp_t q[$];

  always #10 clk = ~clk;

  ijc_unit #(.PC_W(PC_W), .SP_W(16), .HAS_EXT(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .z_i(z),
    .ext_i(ext), .pc_i(pc), .sp_i(sp_in), .mem_rdata_i(rdata),
    .mem_we_o(we), .mem_re_o(re), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .done_o(done), .busy_o(busy), .bad_op_o(bad), .next_pc_o(npc),
    .sp_o(sp_out), .cycles_o(cyc));

  ijc_unit #(.PC_W(PC_W), .SP_W(16), .HAS_EXT(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .z_i(z),
    .ext_i(ext), .pc_i(pc), .sp_i(sp_in), .mem_rdata_i(rdata),
    .mem_we_o(n_we), .mem_re_o(n_re), .mem_addr_o(n_addr), .mem_wdata_o(n_wdata),
    .done_o(n_done), .busy_o(n_busy), .bad_op_o(n_bad), .next_pc_o(n_npc),
    .sp_o(n_sp), .cycles_o(n_cyc));

  always @(posedge clk) if (we) mem[addr] = wdata;
  always @(negedge clk) rdata <= mem.exists(addr) ? mem[addr] : 8'h00;

  function automatic logic [7:0] mrd(logic [15:0] a);
    return mmem.exists(a) ? mmem[a] : 8'h00;
  endfunction

  function automatic exp_t blank(int req);
    exp_t e;
    e.we = 0; e.re = 0; e.done = 0; e.bad = 0; e.busy = 1;
    e.addr = '0; e.wdata = '0; e.npc = '0; e.sp = '0; e.cyc = '0; e.req = req;
    return e;
  endfunction

  exp_t cur;
  bit   mis;
  always @(negedge clk) if (run) begin
    if (q.size() > 0) cur = q.pop_front();
    else begin cur = blank(9); cur.busy = 0; end  // R9 idle
    vectors++;
    mis = (we !== cur.we) || (re !== cur.re) || (done !== cur.done) ||
          (bad !== cur.bad) || (busy !== cur.busy);
    if ((cur.we || cur.re) && addr !== cur.addr) mis = 1;
    if (cur.we && wdata !== cur.wdata) mis = 1;
    if (cur.done && (npc !== cur.npc || sp_out !== cur.sp || cyc !== cur.cyc)) mis = 1;
    if (mis) begin
      miscompares++;
      $display("FAIL R%0d t=%0t act we%b re%b a%h w%h d%b b%b bz%b pc%h sp%h c%0d exp we%b re%b a%h w%h d%b b%b bz%b pc%h sp%h c%0d",
        cur.req, $time, we, re, addr, wdata, done, bad, busy, npc, sp_out, cyc,
        cur.we, cur.re, cur.addr, cur.wdata, cur.done, cur.bad, cur.busy, cur.npc, cur.sp, cur.cyc);
    end
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s act %h exp %h", req, what, act, expv);
    end
  endtask

  // reference model: queues the per-cycle outputs from cycle 2 on
  task automatic expect_op(logic [15:0] o, logic [15:0] zz, logic [7:0] ee,
                           logic [23:0] p, logic [15:0] s);
    exp_t e;
    logic [23:0] tgt;
    logic [15:0] ra;
    logic [7:0]  hi, lo;
    bit fam = (o & 16'hFEEF) == 16'h9409;
    tgt = o[4] ? {ee, zz} : {8'h00, zz};
    if (fam && o[8]) begin  // R4 call
      ra = 16'(p + 24'd1);
      e = blank(4); e.we = 1; e.addr = s; e.wdata = ra[7:0]; q.push_back(e);
      mmem[s] = ra[7:0];
      e = blank(4); e.we = 1; e.addr = s - 16'd1; e.wdata = ra[15:8];
      e.done = 1; e.npc = tgt; e.sp = s - 16'd2; e.cyc = 3; q.push_back(e);
      mmem[s - 16'd1] = ra[15:8];
    end else if (fam) begin  // R2 jump
      e = blank(2); e.done = 1; e.npc = tgt; e.sp = s; e.cyc = 2; q.push_back(e);
    end else if (o == 16'h9508) begin  // R5 return
      hi = mrd(s + 16'd1); lo = mrd(s + 16'd2);
      e = blank(5); e.re = 1; e.addr = s + 16'd1; q.push_back(e);
      e = blank(5); e.re = 1; e.addr = s + 16'd2; q.push_back(e);
      e = blank(5); e.done = 1; e.npc = {8'h00, hi, lo}; e.sp = s + 16'd2; e.cyc = 4;
      q.push_back(e);
    end else begin  // R1 unknown opcode -> reject
      e = blank(1); e.done = 1; e.bad = 1; e.npc = p + 24'd1; e.sp = s; e.cyc = 2;
      q.push_back(e);
    end
  endtask

  task automatic issue(logic [15:0] o, logic [15:0] zz, logic [7:0] ee,
                       logic [23:0] p, logic [15:0] s, bit glitch);
    @(negedge clk); #1;
    op = o; z = zz; ext = ee; pc = p; sp_in = s; start = 1'b1;
    expect_op(o, zz, ee, p, s);
    @(negedge clk);
    if (o[4] && (o & 16'hFEEF) == 16'h9409) begin
      // R3: instance without extension register rejects widened forms
      check(n_done && n_bad, "R3", "u1 done/bad", {30'd0, n_done, n_bad}, 32'd3);
      check(n_npc == p + 24'd1, "R3", "u1 next pc", {8'd0, n_npc}, {8'd0, p + 24'd1});
      check(!n_we && !n_re && n_sp == s, "R3", "u1 stack", {16'd0, n_sp}, {16'd0, s});
    end
    #1;
    if (glitch) begin
      // R8: request while busy must be ignored
      op = 16'h9409; z = 16'h7777; sp_in = 16'h0123; start = 1'b1;
      @(negedge clk); #1;
    end
    start = 1'b0;
    while (q.size() != 0) begin @(negedge clk); #2; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !we && !re, "R9", "reset idle", {28'd0, busy, done, we, re}, 32'd0);
    #1 rst_n = 1'b1;
    run = 1'b1;
    repeat (2) @(negedge clk);
    issue(16'h9409, 16'h1234, 8'hAB, 24'h000010, 16'h08FF, 0);  // R2 ext ignored
    issue(16'h9419, 16'hBEEF, 8'h5A, 24'h000020, 16'h08FF, 0);  // R1 R2 wide jump
    issue(16'h9509, 16'h0100, 8'h77, 24'h00ABCD, 16'h08FF, 0);  // R4 call
    issue(16'h9508, 16'h0000, 8'h00, 24'h000100, 16'h08FD, 0);  // R5 return 0xABCE
    issue(16'h9519, 16'h4321, 8'h01, 24'h12FFFF, 16'h0400, 1);  // R8 glitch, ra carry
    issue(16'h9508, 16'h0000, 8'h00, 24'h014321, 16'h03FE, 0);  // R5 back to 0x0000
    issue(16'h9509, 16'h2222, 8'h00, 24'h003456, 16'h0000, 0);  // R7 wrap down
    issue(16'h9508, 16'h0000, 8'h00, 24'h002222, 16'hFFFE, 0);  // R7 wrap up
    mem[16'h0000] = 8'hC3; mmem[16'h0000] = 8'hC3;
    mem[16'h0001] = 8'h5E; mmem[16'h0001] = 8'h5E;
    issue(16'h9508, 16'h0000, 8'h00, 24'h000500, 16'hFFFF, 0);  // R7 R5 0xC35E
    issue(16'h9408, 16'h1111, 8'h00, 24'h00FFFF, 16'h0200, 0);  // R1 R3 reject
    issue(16'h0000, 16'h1111, 8'h00, 24'hFFFFFF, 16'h0200, 0);  // R1 R3 wrap pc+1
    issue(16'h9589, 16'h1111, 8'h00, 24'h000042, 16'h0200, 0);  // R1 near-miss
    issue(16'h9409, 16'hFFFF, 8'hFF, 24'h000000, 16'h1234, 1);  // R6 R8 jump + glitch
    repeat (3) @(negedge clk);
    run = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule